// File: doc/BRIEF.md
# Relocatable RAM with Write-Once Base Lock

This block is a 2 KB on-chip RAM placed behind a simple register-bus slave port. Software places the array in a 24-bit address map by writing a page number into a base register. The array is switched off after reset and is switched on by a base write that holds a legal page. The base register takes one write after reset and then refuses all further writes. This guards the memory map against runaway code. A test bit, which can be set only while the chip-level test-mode input is high, lifts that lock.

A control register chooses whether user-level masters may reach the array or only supervisor-level masters may. A refused access is not claimed. The bus can then decode it elsewhere. Every access comes with a combinational claim indication and an error indication. Claimed accesses finish with a one-cycle acknowledge after a fixed number of clocks. Data is big-endian: the even byte address sits in bits [15:8] of each 16-bit word.

The register block occupies 64 bytes at a parameterised address, 0xFFFE00 by default. It holds three 16-bit registers, each at a fixed offset:

- 0x00: control. Bit 0, `user_ok`, set to 1 lets user-level masters reach the array.
- 0x02: test. Bit 0, `lock_off`, set to 1 defeats the base lock.
- 0x04: base. Bits [15:3] hold the page number, which is address bits [23:11]. Bit 0 reads back as the disable flag.

Top module: `reloc_ram`

## Requirements
- R1: After reset the base register reads 0x0001, with page 0 and the disable flag (bit 0) set. The control and test registers read 0x0000. No array access is claimed.
- R2: A word write to the base register (offset 0x04) whose page differs from the register block's page clears the disable flag. Afterwards, array accesses whose address bits [23:11] equal the page are claimed.
- R3: A base write whose page equals the register block's own page is stored and reads back with the disable flag still set. The array stays unclaimed.
- R4: After the first base write following reset, further base writes leave the register unchanged. Reads always return the stored value.
- R5: If the first base write covers only one byte lane, the other lane is locked as well. A later word write changes neither half.
- R6: Test bit 0 (offset 0x02) can be written only while `test_mode` is 1. While it is set, the base register can be rewritten any number of times.
- R7: With control bit 0 clear, a user-level access (`bus_sup`=0) to the array is unclaimed and never acknowledged. A supervisor-level access is claimed. With the bit set, both levels are claimed.
- R8: A byte or word access is acknowledged for one cycle, two clock edges after the edge that accepts it. A long-word access (two bus cycles) is acknowledged four edges after acceptance.
- R9: The size code is 0 for byte, 1 for word and 2 for long word. Byte data uses bits [7:0], word data uses [15:0] and long-word data uses [31:0]. Storage is big-endian: the even byte address maps to word bits [15:8], and a long word puts [31:16] at the lower address.
- R10: A word or long-word access with address bit 0 set that falls on the array or the register block raises `bus_err`. It is not claimed and not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| test_mode | input | 1 | Chip test mode; allows writing the lock-defeat bit |
| bus_req | input | 1 | Access request, held until acknowledge or until the master gives up |
| bus_we | input | 1 | 1 = write |
| bus_sup | input | 1 | 1 = supervisor level, 0 = user level |
| bus_size | input | 2 | 0 byte, 1 word, 2 long word |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned to the access size |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| bus_claim | output | 1 | This block decodes the current request |
| bus_err | output | 1 | The request hits this block but is misaligned |
| bus_ack | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is the lock state after a partial first write. The lower byte lane must be frozen without ever having been written. Only a fresh reset followed by a single upper-byte write gets there. The bench therefore resets before each lock scenario and issues exactly that byte write. It then attempts a full word write and reads back both halves. The overlapping-page case and the test-mode unlock each get their own reset, so that no earlier base write has already engaged the lock.

// File: rtl/reloc_ram_pkg.sv
package reloc_ram_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_ARRAY = 2'd1,
        TGT_REGS  = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic claim;
        logic err;
    } dec_t;

    localparam int OFF_CTRL = 0;
    localparam int OFF_TEST = 2;
    localparam int OFF_BASE = 4;

    // Lane enables {upper, lower} for one 16-bit beat; even byte is upper.
    function automatic logic [1:0] beat_lanes(size_e sz, logic a0);
        if (sz == SZ_BYTE) return a0 ? 2'b01 : 2'b10;
        return 2'b11;
    endfunction

endpackage

// File: rtl/reloc_ram_decode.sv
module reloc_ram_decode
    import reloc_ram_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int PAGE_LSB = 11,
    parameter int REG_LSB = 6,
    parameter logic [ADDR_W-1:0] REG_BLK = 24'hFFFE00
) (
    input  logic                       req,
    input  logic [ADDR_W-1:0]          addr,
    input  size_e                      size,
    input  logic                       sup,
    input  logic                       en,
    input  logic                       user_ok,
    input  logic [ADDR_W-PAGE_LSB-1:0] page,
    output dec_t                       dec
);
    logic reg_hit, arr_hit, misal;

    always_comb begin
        reg_hit = (addr[ADDR_W-1:REG_LSB] == REG_BLK[ADDR_W-1:REG_LSB])
                  && (size == SZ_BYTE || size == SZ_WORD);
        arr_hit = en && (addr[ADDR_W-1:PAGE_LSB] == page)
                  && (sup || user_ok) && (size != SZ_RSVD);
        misal   = (size != SZ_BYTE) && addr[0];
        if (reg_hit)      dec.tgt = TGT_REGS;
        else if (arr_hit) dec.tgt = TGT_ARRAY;
        else              dec.tgt = TGT_NONE;
        dec.claim = req && (dec.tgt != TGT_NONE) && !misal;
        dec.err   = req && (dec.tgt != TGT_NONE) && misal;
    end
endmodule

// File: rtl/reloc_ram_regs.sv
module reloc_ram_regs
    import reloc_ram_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int PAGE_LSB = 11,
    parameter int REG_LSB = 6,
    parameter logic [ADDR_W-1:0] REG_BLK = 24'hFFFE00
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       test_mode,
    input  logic                       wr,
    input  logic [REG_LSB-1:0]         off,
    input  logic [1:0]                 lanes,
    input  logic [15:0]                wdata,
    output logic [15:0]                rdata,
    output logic [ADDR_W-PAGE_LSB-1:0] page,
    output logic                       en,
    output logic                       user_ok
);
    localparam int PW = ADDR_W - PAGE_LSB;
    localparam logic [15:0] FIELD_MASK = 16'(((1 << PW) - 1) << (16 - PW));
    localparam logic [PW-1:0] OWN_PAGE = REG_BLK[ADDR_W-1:PAGE_LSB];

    logic [15:0] base_q, merged;
    logic        dis_q, locked_q, lock_off_q, user_ok_q;
    logic        sel_ctrl, sel_test, sel_base, base_open;

    always_comb begin
        sel_ctrl  = off[REG_LSB-1:1] == OFF_CTRL[REG_LSB-1:1];
        sel_test  = off[REG_LSB-1:1] == OFF_TEST[REG_LSB-1:1];
        sel_base  = off[REG_LSB-1:1] == OFF_BASE[REG_LSB-1:1];
        base_open = !locked_q || lock_off_q;
        merged    = base_q;
        if (lanes[1]) merged[15:8] = wdata[15:8];
        if (lanes[0]) merged[7:0]  = wdata[7:0];
        merged    = merged & FIELD_MASK;
        if (sel_ctrl)      rdata = {15'd0, user_ok_q};
        else if (sel_test) rdata = {15'd0, lock_off_q};
        else if (sel_base) rdata = base_q | {15'd0, dis_q};
        else               rdata = 16'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q     <= 16'd0;
            dis_q      <= 1'b1;
            locked_q   <= 1'b0;
            lock_off_q <= 1'b0;
            user_ok_q  <= 1'b0;
        end else if (wr) begin
            if (sel_ctrl && lanes[0]) user_ok_q <= wdata[0];
            if (sel_test && lanes[0] && test_mode) lock_off_q <= wdata[0];
            if (sel_base && base_open) begin
                base_q   <= merged;
                locked_q <= 1'b1;
                dis_q    <= (merged[15 -: PW] == OWN_PAGE);
            end
        end
    end

    assign page    = base_q[15 -: PW];
    assign en      = !dis_q;
    assign user_ok = user_ok_q;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (dis_q && !locked_q && !lock_off_q));
    assert_no_own_page_R3: assert property (@(posedge clk) disable iff (rst)
        !dis_q |-> (base_q[15 -: PW] != OWN_PAGE));
    assert_lock_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (locked_q && !lock_off_q) |=> $stable(base_q));
    assert_lock_set_R5: assert property (@(posedge clk) disable iff (rst)
        (wr && sel_base) |=> locked_q);
    assert_test_gate_R6: assert property (@(posedge clk) disable iff (rst)
        !test_mode |=> (lock_off_q == $past(lock_off_q)));
endmodule

// File: rtl/reloc_ram_array.sv
module reloc_ram_array #(
    parameter int WORDS = 1024,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       lanes,
    input  logic [15:0]      wdata,
    output logic [15:0]      rdata
);
    logic [15:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            if (lanes[1]) mem[idx][15:8] <= wdata[15:8];
            if (lanes[0]) mem[idx][7:0]  <= wdata[7:0];
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/reloc_ram.sv
module reloc_ram
    import reloc_ram_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int RAM_BYTES = 2048,
    parameter int REG_SPAN  = 64,
    parameter logic [ADDR_W-1:0] REG_BLK = 24'hFFFE00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              test_mode,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_sup,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_claim,
    output logic              bus_err,
    output logic              bus_ack
);
    localparam int WORDS    = RAM_BYTES / 2;
    localparam int IDX_W    = $clog2(WORDS);
    localparam int PAGE_LSB = $clog2(RAM_BYTES);
    localparam int REG_LSB  = $clog2(REG_SPAN);
    localparam int PW       = ADDR_W - PAGE_LSB;

    dec_t             dec;
    logic [PW-1:0]    page;
    logic             en, user_ok;

    logic                busy, cyc, half, ack_q;
    logic                we_q;
    tgt_e                tgt_q;
    size_e               size_q;
    logic [PAGE_LSB-1:0] addr_q;
    logic [31:0]         wdata_q, rdata_q;

    logic [IDX_W-1:0] idx;
    logic [1:0]       lanes;
    logic [15:0]      wd16, arr_rd, reg_rd, rd16;
    logic             op, last;

    reloc_ram_decode #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .REG_LSB(REG_LSB),
                       .REG_BLK(REG_BLK)) u_dec (
        .req(bus_req), .addr(bus_addr), .size(size_e'(bus_size)), .sup(bus_sup),
        .en(en), .user_ok(user_ok), .page(page), .dec(dec));

    always_comb begin
        op    = busy && cyc;
        last  = (size_q != SZ_LONG) || half;
        idx   = addr_q[PAGE_LSB-1:1] + IDX_W'(half);
        lanes = beat_lanes(size_q, addr_q[0]);
        case (size_q)
            SZ_BYTE: wd16 = {wdata_q[7:0], wdata_q[7:0]};
            SZ_LONG: wd16 = half ? wdata_q[15:0] : wdata_q[31:16];
            default: wd16 = wdata_q[15:0];
        endcase
        rd16 = (tgt_q == TGT_REGS) ? reg_rd : arr_rd;
    end

    reloc_ram_array #(.WORDS(WORDS), .IDX_W(IDX_W)) u_arr (
        .clk(clk), .we(op && we_q && tgt_q == TGT_ARRAY), .idx(idx),
        .lanes(lanes), .wdata(wd16), .rdata(arr_rd));

    reloc_ram_regs #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .REG_LSB(REG_LSB),
                     .REG_BLK(REG_BLK)) u_regs (
        .clk(clk), .rst(rst), .test_mode(test_mode),
        .wr(op && we_q && tgt_q == TGT_REGS), .off(addr_q[REG_LSB-1:0]),
        .lanes(lanes), .wdata(wd16), .rdata(reg_rd),
        .page(page), .en(en), .user_ok(user_ok));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cyc     <= 1'b0;
            half    <= 1'b0;
            ack_q   <= 1'b0;
            we_q    <= 1'b0;
            tgt_q   <= TGT_NONE;
            size_q  <= SZ_BYTE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            ack_q <= 1'b0;
            if (!busy) begin
                if (dec.claim) begin
                    busy    <= 1'b1;
                    cyc     <= 1'b0;
                    half    <= 1'b0;
                    we_q    <= bus_we;
                    tgt_q   <= dec.tgt;
                    size_q  <= size_e'(bus_size);
                    addr_q  <= bus_addr[PAGE_LSB-1:0];
                    wdata_q <= bus_wdata;
                end
            end else if (!cyc) begin
                cyc <= 1'b1;
            end else begin
                case (size_q)
                    SZ_BYTE: rdata_q <= {24'd0, addr_q[0] ? rd16[7:0] : rd16[15:8]};
                    SZ_LONG: if (half) rdata_q[15:0] <= rd16;
                             else      rdata_q[31:16] <= rd16;
                    default: rdata_q <= {16'd0, rd16};
                endcase
                cyc <= 1'b0;
                if (last) begin
                    busy  <= 1'b0;
                    half  <= 1'b0;
                    ack_q <= 1'b1;
                end else begin
                    half <= 1'b1;
                end
            end
        end
    end

    assign bus_claim = dec.claim;
    assign bus_err   = dec.err;
    assign bus_ack   = ack_q;
    assign bus_rdata = rdata_q;

    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);
    assert_ack_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> $past(busy));
    assert_err_no_start_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !busy) |=> !busy);
    assert_user_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_sup && !user_ok &&
         bus_addr[ADDR_W-1:REG_LSB] != REG_BLK[ADDR_W-1:REG_LSB]) |-> !bus_claim);
endmodule

// File: tb/test_reloc_ram.sv
module test_reloc_ram;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        test_mode = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_sup = 1'b1;
    logic [1:0]  bus_size = 2'd0;
    logic [23:0] bus_addr = 24'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        bus_claim, bus_err, bus_ack;

    int total = 0, bad = 0;
    bit done = 0;

    localparam logic [23:0] A_CTRL = 24'hFFFE00;
    localparam logic [23:0] A_TEST = 24'hFFFE02;
    localparam logic [23:0] A_BASE = 24'hFFFE04;

    always #2.5 clk = ~clk;

    reloc_ram i_reloc_ram (
        .clk(clk), .rst(rst), .test_mode(test_mode), .bus_req(bus_req),
        .bus_we(bus_we), .bus_sup(bus_sup), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_claim(bus_claim), .bus_err(bus_err), .bus_ack(bus_ack));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic sup, input logic we, input logic [1:0] sz,
                       input logic [23:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output logic cl, output logic er,
                       output int lat);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_sup = sup; bus_size = sz;
        bus_addr = a; bus_wdata = wd;
        #1;
        cl = bus_claim; er = bus_err; lat = 0; rd = 32'd0;
        if (cl) begin
            while (lat < 20) begin
                @(negedge clk);
                lat++;
                if (bus_ack) break;
            end
            rd = bus_rdata;
        end else begin
            repeat (3) begin
                @(negedge clk);
                if (bus_ack) lat = 99;
            end
        end
        bus_req = 1'b0;
    endtask

    task automatic do_reset(input logic tm);
        @(negedge clk);
        rst = 1'b1; test_mode = tm;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr16(input logic [23:0] a, input logic [31:0] d);
        logic [31:0] rd; logic cl, er; int lat;
        acc(1'b1, 1'b1, 2'd1, a, d, rd, cl, er, lat);
    endtask

    task automatic rd16(input logic [23:0] a, output logic [31:0] rd);
        logic cl, er; int lat;
        acc(1'b1, 1'b0, 2'd1, a, 32'd0, rd, cl, er, lat);
    endtask

    task automatic t_reset;
        logic [31:0] rd; logic cl, er; int lat;
        do_reset(1'b0);
        rd16(A_BASE, rd);  chk("R1 base after reset", rd, 32'h0001);
        rd16(A_CTRL, rd);  chk("R1 ctrl after reset", rd, 32'h0000);
        rd16(A_TEST, rd);  chk("R1 test after reset", rd, 32'h0000);
        acc(1'b1, 1'b0, 2'd1, 24'h000000, 0, rd, cl, er, lat);
        chk("R1 array unclaimed", {31'd0, cl}, 32'd0);
        wr16(A_TEST, 32'h0001);
        rd16(A_TEST, rd);  chk("R6 test bit ignored outside test mode", rd, 32'h0000);
    endtask

    task automatic t_overlap;
        logic [31:0] rd; logic cl, er; int lat;
        do_reset(1'b0);
        wr16(A_BASE, 32'hFFF8);
        rd16(A_BASE, rd);  chk("R3 own page stored, still disabled", rd, 32'hFFF9);
        acc(1'b1, 1'b0, 2'd1, 24'hFFF800, 0, rd, cl, er, lat);
        chk("R3 array unclaimed", {31'd0, cl}, 32'd0);
        wr16(A_BASE, 32'h1008);
        rd16(A_BASE, rd);  chk("R4 locked after first write", rd, 32'hFFF9);
    endtask

    task automatic t_main;
        logic [31:0] rd; logic cl, er; int lat;
        do_reset(1'b0);
        wr16(A_BASE, 32'h1008);
        rd16(A_BASE, rd);  chk("R2 base enabled", rd, 32'h1008);
        wr16(A_BASE, 32'h2000);
        rd16(A_BASE, rd);  chk("R4 second write ignored", rd, 32'h1008);
        acc(1'b1, 1'b1, 2'd0, 24'h100801, 32'hA5, rd, cl, er, lat);
        chk("R2 array claimed", {31'd0, cl}, 32'd1);
        chk("R8 byte latency", lat, 3);
        acc(1'b1, 1'b1, 2'd0, 24'h100800, 32'h3C, rd, cl, er, lat);
        acc(1'b1, 1'b0, 2'd1, 24'h100800, 0, rd, cl, er, lat);
        chk("R9 bytes big-endian", rd, 32'h3CA5);
        chk("R8 word latency", lat, 3);
        acc(1'b1, 1'b1, 2'd2, 24'h100810, 32'h11223344, rd, cl, er, lat);
        chk("R8 long write latency", lat, 5);
        acc(1'b1, 1'b0, 2'd1, 24'h100812, 0, rd, cl, er, lat);
        chk("R9 long low half at addr+2", rd, 32'h3344);
        acc(1'b1, 1'b0, 2'd2, 24'h100810, 0, rd, cl, er, lat);
        chk("R9 long read", rd, 32'h11223344);
        chk("R8 long read latency", lat, 5);
        acc(1'b1, 1'b0, 2'd0, 24'h100811, 0, rd, cl, er, lat);
        chk("R9 odd byte read", rd, 32'h22);
        acc(1'b0, 1'b0, 2'd1, 24'h100800, 0, rd, cl, er, lat);
        chk("R7 user unclaimed", {31'd0, cl}, 32'd0);
        chk("R7 user no ack", lat, 0);
        wr16(A_CTRL, 32'h0001);
        acc(1'b0, 1'b0, 2'd1, 24'h100800, 0, rd, cl, er, lat);
        chk("R7 user claimed when allowed", {31'd0, cl}, 32'd1);
        chk("R7 user read data", rd, 32'h3CA5);
        acc(1'b1, 1'b0, 2'd1, 24'h100801, 0, rd, cl, er, lat);
        chk("R10 misaligned error", {30'd0, cl, er}, 32'd1);
        chk("R10 misaligned no ack", lat, 0);
    endtask

    task automatic t_partial;
        logic [31:0] rd; logic cl, er; int lat;
        do_reset(1'b0);
        acc(1'b1, 1'b1, 2'd0, A_BASE, 32'h10, rd, cl, er, lat);
        wr16(A_BASE, 32'h10F8);
        rd16(A_BASE, rd);  chk("R5 both halves locked", rd, 32'h1000);
        acc(1'b1, 1'b0, 2'd1, 24'h100000, 0, rd, cl, er, lat);
        chk("R5 array on byte-written page", {31'd0, cl}, 32'd1);
    endtask

    task automatic t_unlock;
        logic [31:0] rd; logic cl, er; int lat;
        do_reset(1'b1);
        wr16(A_TEST, 32'h0001);
        rd16(A_TEST, rd);  chk("R6 test bit set", rd, 32'h0001);
        wr16(A_BASE, 32'h1008);
        wr16(A_BASE, 32'h2008);
        rd16(A_BASE, rd);  chk("R6 rewrite with lock off", rd, 32'h2008);
        acc(1'b1, 1'b0, 2'd1, 24'h200800, 0, rd, cl, er, lat);
        chk("R6 new page claimed", {31'd0, cl}, 32'd1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_overlap();
        t_main();
        t_partial();
        t_unlock();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule